// File: doc/BRIEF.md
# Inverse-Time Overcurrent Trip Unit

This block decides when a protected line must be disconnected. On every clock it takes one sample of the line current and one copy of a pickup level that software or a neighbouring block can change while the unit runs. When the current is above the pickup level, the unit times how long that condition lasts. It raises its single trip output once that duration reaches a delay that depends on the current. Large overcurrents trip quickly and mild ones trip slowly, which gives an inverse-time characteristic.

The work is split into three register-separated stages that all load on the same clock edge. The front stage registers both inputs and, from the registered current, produces a fault flag and a time-to-trip figure. The figure comes from a table that is built when the design is elaborated. The middle stage keeps a fault-duration counter and carries the time-to-trip of the same sample beside it. The last stage compares the two values and latches the trip. Only the synchronous reset clears a latched trip. Both data inputs are sampled on every clock with no handshake, because a protection path must never stall. The house rule of valid/ready streams therefore does not apply here.

Top module: `otrip_unit`

## Requirements
- R1: A sample counts as a fault only when the current is strictly greater than the pickup level. Holding the current equal to the pickup level for any length of time never trips.
- R2: The time-to-trip for current code c is MIN_DLY + SPAN / (c + 1), using integer division. The result is at least one clock and never increases as c grows.
- R3: If the fault starts with the sample taken at clock edge e and continues, trip first reads 1 after edge e + T + 1, where T is the time-to-trip of the sampled current. Before that edge it reads 0.
- R4: A single sample that is not a fault sets the duration counter back to zero. The timing of a later fault then starts over.
- R5: Once set, trip stays 1 until reset, even after the current falls below the pickup level.
- R6: rst is active high and synchronous. After a reset edge, trip reads 0 and all pipeline state is idle. A sample taken during reset is never treated as a fault.
- R7: A change to the pickup level takes effect on the next sample. Raising it above the current stops the timing before a trip.
- R8: The duration counter is CW bits wide and stops at 2**CW - 1 instead of wrapping. If a current's time-to-trip is larger than that value, that current never trips.
- R9: Each comparison uses the time-to-trip of the same sample as the fault count. If the current steps up during a fault, the shorter delay applies to the count built up so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages load on its rising edge |
| rst | input | 1 | Synchronous active-high reset; the only way to clear a trip |
| line_cur | input | DW | Sampled line current code |
| pickup_lvl | input | DW | Pickup level; currents above it are faults |
| trip | output | 1 | Latched trip request |

## Verification
The bench builds the unit with DW=8, CW=6, SPAN=130 and MIN_DLY=3. With these values the delays are short, from 3 clocks at full scale to 46 clocks at code 2. Code 1 needs 68 clocks, which is beyond the 63-count ceiling, so the saturation rule can be observed at the trip pin. Code 2 needs a delay close to that ceiling, and a step from code 3 to full scale shows that the fault count and the delay stay paired through the middle stage.

// File: rtl/otrip_pkg.sv
package otrip_pkg;
  // inverse-time curve: floor delay plus a term shrinking with current
  function automatic int curve_delay(input int code, input int span, input int floor_dly);
    return floor_dly + span / (code + 1);
  endfunction
endpackage

// File: rtl/otrip_curve.sv
module otrip_curve #(
  parameter int DW      = 8,
  parameter int TW      = 11,
  parameter int SPAN    = 2000,
  parameter int MIN_DLY = 4
) (
  input  logic [DW-1:0] idx_i,
  output logic [TW-1:0] ttt_o
);
  localparam int ENTRIES = 1 << DW;

  logic [TW-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tbl[g] = TW'(otrip_pkg::curve_delay(g, SPAN, MIN_DLY));
  end

  assign ttt_o = tbl[idx_i];
endmodule

// File: rtl/otrip_front.sv
module otrip_front #(
  parameter int DW      = 8,
  parameter int TW      = 11,
  parameter int SPAN    = 2000,
  parameter int MIN_DLY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] thr_i,
  output logic          fc_o,
  output logic [TW-1:0] ttt_o
);
  logic [DW-1:0] cur_q, thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      thr_q <= '0;
    end else begin
      cur_q <= cur_i;
      thr_q <= thr_i;
    end
  end

  assign fc_o = cur_q > thr_q;

  otrip_curve #(.DW(DW), .TW(TW), .SPAN(SPAN), .MIN_DLY(MIN_DLY)) u_curve (
    .idx_i (cur_q),
    .ttt_o (ttt_o)
  );

  // R1
  eq_not_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_i <= thr_i) |=> !fc_o);
endmodule

// File: rtl/otrip_timer.sv
module otrip_timer #(
  parameter int CW = 12,
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fc_i,
  input  logic [TW-1:0] ttt_i,
  output logic          fc_o,
  output logic [CW-1:0] cnt_o,
  output logic [TW-1:0] ttt_o
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      fc_o  <= 1'b0;
      ttt_o <= '0;
    end else begin
      fc_o  <= fc_i;
      ttt_o <= ttt_i;
      if (!fc_i)              cnt_o <= '0;
      else if (cnt_o != CMAX) cnt_o <= cnt_o + CW'(1);
    end
  end

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !fc_i |=> (cnt_o == '0));
  // R8
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fc_i && cnt_o == CMAX) |=> (cnt_o == CMAX));
  // R9
  ttt_pair_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ttt_o == $past(ttt_i)));
endmodule

// File: rtl/otrip_decide.sv
module otrip_decide #(
  parameter int CW = 12,
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fc_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [TW-1:0] ttt_i,
  output logic          trip_o
);
  localparam int CMPW = (CW > TW) ? CW : TW;

  logic [CMPW-1:0] cnt_w, ttt_w;
  logic            due;

  assign cnt_w = CMPW'(cnt_i);
  assign ttt_w = CMPW'(ttt_i);
  assign due   = fc_i && (cnt_w >= ttt_w);

  always_ff @(posedge clk) begin
    if (rst)      trip_o <= 1'b0;
    else if (due) trip_o <= 1'b1;
  end

  // R5
  trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> trip_o);
  // R3
  trip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> $past(fc_i && (cnt_w >= ttt_w)));
endmodule

// File: rtl/otrip_unit.sv
module otrip_unit #(
  parameter int DW      = 8,
  parameter int CW      = 12,
  parameter int SPAN    = 2000,
  parameter int MIN_DLY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] line_cur,
  input  logic [DW-1:0] pickup_lvl,
  output logic          trip
);
  localparam int TW = $clog2(MIN_DLY + SPAN + 1);

  logic          fc1, fc2;
  logic [TW-1:0] ttt1, ttt2;
  logic [CW-1:0] cnt2;

  otrip_front #(.DW(DW), .TW(TW), .SPAN(SPAN), .MIN_DLY(MIN_DLY)) u_front (
    .clk   (clk),
    .rst   (rst),
    .cur_i (line_cur),
    .thr_i (pickup_lvl),
    .fc_o  (fc1),
    .ttt_o (ttt1)
  );

  otrip_timer #(.CW(CW), .TW(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .fc_i  (fc1),
    .ttt_i (ttt1),
    .fc_o  (fc2),
    .cnt_o (cnt2),
    .ttt_o (ttt2)
  );

  otrip_decide #(.CW(CW), .TW(TW)) u_decide (
    .clk    (clk),
    .rst    (rst),
    .fc_i   (fc2),
    .cnt_i  (cnt2),
    .ttt_i  (ttt2),
    .trip_o (trip)
  );

  // R6
  reset_clear_chk: assert property (@(posedge clk) rst |=> !trip);
endmodule

// File: tb/otrip_unit_bench.sv
module otrip_unit_bench;
  localparam int DW = 8, CW = 6, SPAN = 130, MIN_DLY = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, trip;
  logic [DW-1:0] line_cur = '0, pickup_lvl = '0;

  always #2.5 clk = ~clk;

  otrip_unit #(.DW(DW), .CW(CW), .SPAN(SPAN), .MIN_DLY(MIN_DLY)) u_otrip_unit (
    .clk(clk), .rst(rst), .line_cur(line_cur), .pickup_lvl(pickup_lvl), .trip(trip)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t sbq[$];

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int run = 0;
  bit prev_rst = 1, c_d1 = 0, c_d2 = 0, latch = 0;

  function automatic int ref_ttt(int c);
    return MIN_DLY + SPAN / (c + 1);
  endfunction

  task automatic drive(bit r, int cur, int thr, string tag);
    bit fault, c;
    item_t it;
    @(negedge clk);
    rst = r; line_cur = DW'(cur); pickup_lvl = DW'(thr);
    fault = cur > thr;
    if (!r && fault) run = (run < CMAX) ? run + 1 : CMAX;
    else run = 0;
    c = !r && fault && (run >= ref_ttt(cur));
    if (r) latch = 0;
    else if (!prev_rst && c_d2) latch = 1;
    it.exp = latch; it.tag = tag;
    sbq.push_back(it);
    c_d2 = c_d1; c_d1 = c; prev_rst = r;
  endtask

  task automatic hold(int n, bit r, int cur, int thr, string tag);
    for (int i = 0; i < n; i++) drive(r, cur, thr, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (trip !== it.exp) begin
          bad++;
          $display("FAIL %s: trip=%0b expected=%0b at %0t", it.tag, trip, it.exp, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    hold(3, 1, 0, 0, "R6 reset state");
    hold(300, 0, 50, 50, "R1 equal level");
    // R3: full scale, delay 3
    hold(2, 1, 0, 0, "R6");
    hold(10, 0, 255, 10, "R3 full scale");
    // R2: code 9, delay 16
    hold(2, 1, 0, 0, "R6");
    hold(25, 0, 9, 0, "R2 code 9");
    hold(20, 0, 0, 40, "R5 latched");
    hold(1, 1, 0, 0, "R6 clear");
    hold(6, 0, 0, 0, "R6 idle");
    // R4: code 20 delay 9, interrupted runs
    for (int k = 0; k < 4; k++) begin
      hold(8, 0, 20, 5, "R4 run");
      hold(1, 0, 20, 25, "R4 gap");
    end
    hold(14, 0, 20, 5, "R4 final run");
    // R7: code 100 delay 4
    hold(2, 1, 0, 0, "R6");
    hold(2, 0, 100, 99, "R7 start");
    hold(20, 0, 100, 100, "R7 raised");
    hold(10, 0, 100, 50, "R7 lowered");
    // R8: code 1 delay 68 > 63, never trips; code 2 delay 46 trips
    hold(2, 1, 0, 0, "R6");
    hold(300, 0, 1, 0, "R8 saturated");
    hold(2, 1, 0, 0, "R6");
    hold(52, 0, 2, 0, "R8 near ceiling");
    // R9: code 3 (delay 35) then full scale (delay 3)
    hold(2, 1, 0, 0, "R6");
    hold(20, 0, 3, 0, "R9 low");
    hold(6, 0, 255, 0, "R9 step up");
    hold(3, 0, 0, 0, "R9 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule